// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block controls an 8-bit general-purpose I/O port. Each bit can be a software output, a software input, a peripheral output or a peripheral input. Two registers set its behaviour: a port data register, which is the output latch, and a direction register. A small register bus writes and reads both registers. A separate qualifier on the bus marks a read as the read half of a read-modify-write instruction. A tri-state pad interface drives the pins: output value, output enable and input value.

Each peripheral has its own per-bit output enable and data. When a peripheral's enable is set for a bit, the peripheral overrides that bit. Pad inputs pass through a synchronizer. The synchronized levels go to the data-register readback and to the peripherals.

Each bit is in one of three modes:
- `MODE_PERIPH_OUT` when its peripheral enable is set. This mode has priority.
- `MODE_SW_OUT` when its direction bit is 1 and its peripheral enable is clear.
- `MODE_INPUT` otherwise.

The mode follows the enables and the direction bit in the same cycle. Register address 0 selects the data register and address 1 selects the direction register.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset, every direction bit and every latch bit is 0, no pad is driven (with peripheral enables clear), and the read data is 0.
- R2: A bit whose direction bit is 1 and whose peripheral enable is clear drives the pad with its latch value, and its pad output enable is 1.
- R3: A write to the data register updates the latch even for bits whose direction bit is 0. Such bits keep their pad output enable at 0, and a read-modify-write read returns the new latch value.
- R4: A normal read of address 0 returns the latch for software-output bits and the synchronized pin level for every other bit.
- R5: A read of address 0 with the read-modify-write flag set returns the latch for all bits, whatever the direction, peripheral or pin state.
- R6: A set peripheral output enable forces the pad output enable to 1 and drives the peripheral's data onto the pad, whatever the direction bit.
- R7: A normal read of a peripheral-driven bit returns the pin level, and so reflects the peripheral's output.
- R8: A pin change is seen by the readback and the peripheral inputs only after two clock edges of synchronization.
- R9: Writes take effect on the clock edge that samples the write strobe. Read data is registered on the edge that samples the read strobe and holds until the next read.
- R10: A read of address 1 returns the stored direction value, independent of pin state and of the read-modify-write flag.
- R11: The peripheral input bus carries the synchronized pin level for every bit, whatever its mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 1 | Register select: 0 data, 1 direction |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rmw | input | 1 | Marks the read as read-modify-write |
| bus_rdata | output | 8 | Registered read data |
| periph_oe | input | 8 | Per-bit peripheral output enable |
| periph_dout | input | 8 | Per-bit peripheral output data |
| periph_din | output | 8 | Synchronized pin levels for peripherals |
| pad_in | input | 8 | Pad input level |
| pad_out | output | 8 | Pad output value |
| pad_oe | output | 8 | Pad output enable |

## Verification
The bench builds the block with the default width of 8 and a two-stage synchronizer. With eight bits, random direction, enable and pin patterns mix all three modes in a single read, so per-bit readback selection is exercised bit against bit. The two-stage depth makes the exact latency reachable: one read is timed to land one edge before a pin change arrives, and the next read lands one edge after it.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int REG_DATA = 0;
    localparam int REG_DIR  = 1;

    typedef enum logic [1:0] {
        MODE_INPUT      = 2'd0,
        MODE_SW_OUT     = 2'd1,
        MODE_PERIPH_OUT = 2'd2
    } pin_mode_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else if (s == 0) begin
                stage_q[s] <= async_i;
            end else begin
                stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter int ADDR_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic [WIDTH-1:0]  wdata_i,
    output logic [WIDTH-1:0]  latch_o,
    output logic [WIDTH-1:0]  dir_o
);
    logic sel_data, sel_dir;

    assign sel_data = (addr_i == ADDR_W'(REG_DATA));
    assign sel_dir  = (addr_i == ADDR_W'(REG_DIR));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_o <= '0;
            dir_o   <= '0;
        end else if (wr_i) begin
            if (sel_data) latch_o <= wdata_i;
            if (sel_dir)  dir_o   <= wdata_i;
        end
    end

    // R3: a data write lands in the latch regardless of direction
    p_latch_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel_data) |=> (latch_o == $past(wdata_i)));

    // R9: a direction write takes effect on the sampling edge
    p_dir_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel_dir) |=> (dir_o == $past(wdata_i)));
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] latch_i,
    input  logic [WIDTH-1:0] dir_i,
    input  logic [WIDTH-1:0] periph_oe_i,
    input  logic [WIDTH-1:0] periph_dout_i,
    input  logic [WIDTH-1:0] pin_sync_i,
    output logic [WIDTH-1:0] pad_out_o,
    output logic [WIDTH-1:0] pad_oe_o,
    output logic [WIDTH-1:0] norm_rd_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        pin_mode_e mode;

        always_comb begin
            if (periph_oe_i[b])  mode = MODE_PERIPH_OUT;
            else if (dir_i[b])   mode = MODE_SW_OUT;
            else                 mode = MODE_INPUT;
        end

        always_comb begin
            pad_out_o[b] = 1'b0;
            pad_oe_o[b]  = 1'b0;
            norm_rd_o[b] = pin_sync_i[b];
            unique case (mode)
                MODE_PERIPH_OUT: begin
                    pad_out_o[b] = periph_dout_i[b];
                    pad_oe_o[b]  = 1'b1;
                end
                MODE_SW_OUT: begin
                    pad_out_o[b] = latch_i[b];
                    pad_oe_o[b]  = 1'b1;
                    norm_rd_o[b] = latch_i[b];
                end
                MODE_INPUT: begin
                    pad_out_o[b] = latch_i[b];
                    pad_oe_o[b]  = 1'b0;
                end
                default: begin
                    pad_oe_o[b]  = 1'b0;
                end
            endcase
        end

        // R6: peripheral enable wins over the direction bit
        p_periph_prio_r6: assert property (@(posedge clk) disable iff (!rst_n)
            periph_oe_i[b] |-> (pad_oe_o[b] && (pad_out_o[b] == periph_dout_i[b])));

        // R3: an input bit never drives its pad
        p_input_undriven_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (!periph_oe_i[b] && !dir_i[b]) |-> !pad_oe_o[b]);
    end
endmodule

// File: rtl/gpio_readback.sv
module gpio_readback
    import gpio_port_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter int ADDR_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    input  logic              rmw_i,
    input  logic [WIDTH-1:0]  latch_i,
    input  logic [WIDTH-1:0]  dir_i,
    input  logic [WIDTH-1:0]  norm_rd_i,
    output logic [WIDTH-1:0]  rdata_o
);
    logic sel_data;
    assign sel_data = (addr_i == ADDR_W'(REG_DATA));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_o <= '0;
        end else if (rd_i) begin
            if (sel_data) rdata_o <= rmw_i ? latch_i : norm_rd_i;
            else          rdata_o <= dir_i;
        end
    end

    // R5: a read-modify-write read returns the latch
    p_rmw_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && rmw_i && sel_data) |=> (rdata_o == $past(latch_i)));

    // R10: a direction read returns the stored direction
    p_dir_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && !sel_data) |=> (rdata_o == $past(dir_i)));

    // R9: read data holds between reads
    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(rdata_o));
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl #(
    parameter int WIDTH       = 8,
    parameter int ADDR_W      = 1,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [WIDTH-1:0]  bus_wdata,
    input  logic              bus_rd,
    input  logic              bus_rmw,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  periph_oe,
    input  logic [WIDTH-1:0]  periph_dout,
    output logic [WIDTH-1:0]  periph_din,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe
);
    logic [WIDTH-1:0] latch_q, dir_q, pin_sync, norm_rd;

    gpio_regs #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr_i(bus_addr), .wr_i(bus_wr),
        .wdata_i(bus_wdata), .latch_o(latch_q), .dir_o(dir_q)
    );

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(pad_in), .sync_o(pin_sync)
    );

    gpio_pad_mux #(.WIDTH(WIDTH)) u_mux (
        .clk(clk), .rst_n(rst_n), .latch_i(latch_q), .dir_i(dir_q),
        .periph_oe_i(periph_oe), .periph_dout_i(periph_dout),
        .pin_sync_i(pin_sync), .pad_out_o(pad_out), .pad_oe_o(pad_oe),
        .norm_rd_o(norm_rd)
    );

    gpio_readback #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_rb (
        .clk(clk), .rst_n(rst_n), .addr_i(bus_addr), .rd_i(bus_rd),
        .rmw_i(bus_rmw), .latch_i(latch_q), .dir_i(dir_q),
        .norm_rd_i(norm_rd), .rdata_o(bus_rdata)
    );

    // R11: peripherals see the synchronized pin in every mode
    assign periph_din = pin_sync;
endmodule

// File: tb/gpio_port_ctrl_test.sv
module gpio_port_ctrl_test;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [0:0]   bus_addr = '0;
    logic         bus_wr = 1'b0, bus_rd = 1'b0, bus_rmw = 1'b0;
    logic [W-1:0] bus_wdata = '0, bus_rdata;
    logic [W-1:0] periph_oe = '0, periph_dout = '0, periph_din;
    logic [W-1:0] pad_in, pad_out, pad_oe, ext_drive = '0;

    int n_checks = 0, n_fail = 0;
    logic [W-1:0] m_latch = '0, m_dir = '0;
    bit done = 0;

    always #10 clk = ~clk;

    // pin model: driven pads show the driven value, others the external level
    assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext_drive);

    gpio_port_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rmw(bus_rmw),
        .bus_rdata(bus_rdata), .periph_oe(periph_oe), .periph_dout(periph_dout),
        .periph_din(periph_din), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    function automatic logic [W-1:0] f_oe(input logic [W-1:0] poe, input logic [W-1:0] dir);
        return poe | dir;
    endfunction
    function automatic logic [W-1:0] f_out(input logic [W-1:0] poe, input logic [W-1:0] pd,
                                           input logic [W-1:0] dir, input logic [W-1:0] lat);
        return (poe & pd) | (~poe & lat);
    endfunction
    function automatic logic [W-1:0] f_pin(input logic [W-1:0] poe, input logic [W-1:0] pd,
                                           input logic [W-1:0] dir, input logic [W-1:0] lat,
                                           input logic [W-1:0] ext);
        return (poe & pd) | (~poe & dir & lat) | (~poe & ~dir & ext);
    endfunction
    function automatic logic [W-1:0] f_norm(input logic [W-1:0] poe, input logic [W-1:0] dir,
                                            input logic [W-1:0] lat, input logic [W-1:0] pin);
        return (~poe & dir & lat) | ((poe | ~dir) & pin);
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic a, input logic [W-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        if (a) m_dir = d; else m_latch = d;
    endtask

    task automatic bus_read(input logic a, input logic rmw, output logic [W-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_rmw = rmw; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; bus_rmw = 1'b0;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        logic [W-1:0] rd, pin;
        void'($urandom(32'd4711));

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 pad_oe in reset", pad_oe, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rdata after reset", bus_rdata, '0);
        bus_read(1'b1, 1'b0, rd);
        check("R1 dir reset", rd, '0);
        bus_read(1'b0, 1'b1, rd);
        check("R1 latch reset", rd, '0);

        // R3: write with all inputs: latch set, pads undriven
        bus_write(1'b0, 8'hA5);
        check("R3 pad_oe stays off", pad_oe, '0);
        bus_read(1'b0, 1'b1, rd);
        check("R3 rmw sees latch", rd, 8'hA5);

        // R9: direction write takes effect on the sampling edge
        @(negedge clk);
        bus_addr = 1'b1; bus_wdata = 8'h0F; bus_wr = 1'b1;
        #1 check("R9 not before edge", pad_oe, 8'h00);
        @(negedge clk);
        bus_wr = 1'b0; m_dir = 8'h0F;
        check("R9 after edge / R2 oe", pad_oe, 8'h0F);
        check("R2 pad_out latch", pad_out & 8'h0F, 8'h05);

        // R8: two-edge synchronizer latency on an input bit
        ext_drive = 8'h00; settle();
        @(negedge clk);
        ext_drive = 8'hF0;
        @(negedge clk);
        check("R8 periph_din one edge", periph_din & 8'hF0, 8'h00);
        bus_addr = 1'b0; bus_rmw = 1'b0; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        check("R8 read too early", bus_rdata & 8'hF0, 8'h00);
        check("R8 periph_din two edges", periph_din & 8'hF0, 8'hF0);
        bus_read(1'b0, 1'b0, rd);
        check("R8 read after sync", rd & 8'hF0, 8'hF0);

        // R6/R7: peripheral overrides a software output bit
        periph_oe = 8'h81; periph_dout = 8'h80;
        settle();
        check("R6 oe", pad_oe, 8'h8F);
        check("R6 out", pad_out & 8'h81, 8'h80);
        bus_read(1'b0, 1'b0, rd);
        check("R7 normal read shows periph", rd & 8'h81, 8'h80);
        bus_read(1'b0, 1'b1, rd);
        check("R5 rmw shows latch", rd, 8'hA5);
        bus_read(1'b1, 1'b1, rd);
        check("R10 dir with rmw flag", rd, 8'h0F);

        // random mix of modes
        for (int i = 0; i < 60; i++) begin
            bus_write(1'b0, W'($urandom));
            bus_write(1'b1, W'($urandom));
            periph_oe = W'($urandom); periph_dout = W'($urandom); ext_drive = W'($urandom);
            settle();
            pin = f_pin(periph_oe, periph_dout, m_dir, m_latch, ext_drive);
            check("R2/R6 pad_oe", pad_oe, f_oe(periph_oe, m_dir));
            check("R2/R6 pad_out on driven bits", pad_out & pad_oe,
                  f_out(periph_oe, periph_dout, m_dir, m_latch) & f_oe(periph_oe, m_dir));
            check("R11 periph_din", periph_din, pin);
            bus_read(1'b0, 1'b0, rd);
            check("R4/R7 normal read", rd, f_norm(periph_oe, m_dir, m_latch, pin));
            bus_read(1'b0, 1'b1, rd);
            check("R5 rmw read", rd, m_latch);
            bus_read(1'b1, 1'b0, rd);
            check("R10 dir read", rd, m_dir);
            repeat (2) @(negedge clk);
            check("R9 rdata holds", bus_rdata, m_dir);
        end
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule